// File: doc/BRIEF.md
# NAND Ready-Wait Status Poller

This engine sits inside a NAND flash controller and tells software when the flash array has finished an operation, on boards where no ready/busy line is wired. It takes one wait command word from the controller's command queue. After the queue has drained and a tWB settle time has passed, it latches the STATUS opcode into the selected chip. It then keeps re-reading the status byte on the IO bus until the ready bit reads 1, so software does not have to loop on register reads.

When ready is seen, the engine can raise a sticky interrupt. If the pending operation was a read, it also issues a READ0 latch cycle to return the chip to data output. The command word carries a clock budget, normally sized to the worst-case erase time. If that budget runs out first, the engine stops polling, sets a sticky timeout flag and goes back to idle. Software clears both flags by writing one to them.

Top module: `nand_rdy_poll`

## Requirements
- R1: A command word is taken as a wait only when all of these hold: bit 20 (ready/busy flag) is 1, bits 13:10 equal 0xB, bit 16 is 1 and bit 18 is 1. Any other word is consumed and causes no bus activity and no flag change.
- R2: `cmd_ready_o` is high only while the engine is idle. No word is accepted while a wait is in progress.
- R3: After a wait is accepted, the bus stays quiet (all CE# high) until `queue_empty_i` is high. After that, exactly `twb_cycles_i` further clocks pass before CE# falls.
- R4: During every latch cycle, only the chip selected by bits 23:22 has CE# low and CLE is high for two clocks. WE# is low in the first of those clocks and high in the second. The first latch carries 0x70 (STATUS).
- R5: Ten idle clocks (two spans of five) separate the end of the STATUS latch from the first RE# fall.
- R6: Each status read holds RE# low for `re_low_i` clocks, with 0 treated as 1. IO is sampled in the last low clock. RE# stays high for at least one clock between reads, and RE# is never low while CLE is high.
- R7: Polling stops at the first read whose bit 6 is 1. When `cfg_irq_en_i` is 1, `irq_o` is then set. Other status bits do not count as ready.
- R8: `irq_o` never becomes set while `cfg_irq_en_i` is 0.
- R9: When bit 17 of the wait word is 1, a READ0 (0x00) latch follows ready. When bit 17 is 0, no second latch occurs.
- R10: Bits 9:0 set the poll budget in clocks. When it expires without ready, the engine sets `timeout_o` instead of `irq_o`, issues no READ0, releases CE# and returns to idle. Budget B with a 3-clock RE# low yields exactly 7 read pulses for B=25.
- R11: `irq_o` and `timeout_o` hold until their own clear input is pulsed. Each clear affects only its own flag.
- R12: After reset, CE# is all high, CLE is low, WE# and RE# are high, the IO driver is off, both flags are low and `cmd_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command word present |
| cmd_word_i | input | 32 | Command word from the queue |
| cmd_ready_o | output | 1 | Engine idle, word consumed this clock |
| queue_empty_i | input | 1 | Controller command queue is drained |
| twb_cycles_i | input | TWB_W | tWB settle time in clocks |
| re_low_i | input | RE_W | RE# low width in clocks |
| cfg_irq_en_i | input | 1 | Ready interrupt enable |
| clr_irq_i | input | 1 | Write-one-to-clear of the interrupt flag |
| clr_tmo_i | input | 1 | Write-one-to-clear of the timeout flag |
| ce_n_o | output | NUM_CS | Chip enables, active low |
| cle_o | output | 1 | Command latch enable |
| we_n_o | output | 1 | Write enable, active low |
| re_n_o | output | 1 | Read enable, active low |
| io_o | output | 8 | IO bus out |
| io_oe_o | output | 1 | IO bus driver enable |
| io_i | input | 8 | IO bus in |
| irq_o | output | 1 | Sticky ready interrupt |
| timeout_o | output | 1 | Sticky budget-expired flag |

## Verification
The assertions assume that the clear inputs are single-clock pulses from software. They also assume that `cfg_irq_en_i` is steady around the cycle ready is found, and that the flash model only drives the status byte while RE# is low. The bench keeps to these assumptions. Its flash model returns a byte only during RE# low and counts reads on the RE# rising edge, so each sample the engine takes sees a stable byte. The bench changes the enable and the timing inputs only while the engine is idle. It pulses the clears only between waits.

// File: rtl/nrp_pkg.sv
package nrp_pkg;
  localparam int CMD_W       = 32;
  localparam int BUDGET_W    = 10;
  localparam int CS_FW       = 2;
  localparam int CS_LSB      = 22;
  localparam int RB_FLAG_BIT = 20;
  localparam int MARK_HI_BIT = 18;
  localparam int RDTERM_BIT  = 17;
  localparam int MARK_LO_BIT = 16;
  localparam int MODE_LSB    = 10;
  localparam int MODE_W      = 4;
  localparam logic [MODE_W-1:0] MODE_POLL = 4'hB;
  localparam logic [7:0] OP_STATUS = 8'h70;
  localparam logic [7:0] OP_READ0  = 8'h00;
  localparam int READY_BIT   = 6;

  typedef enum logic [3:0] {
    ST_IDLE, ST_DRAIN, ST_TWB, ST_STAT_LO, ST_STAT_HI, ST_GAP1, ST_GAP2,
    ST_RE_LO, ST_RE_HI, ST_RD0_LO, ST_RD0_HI
  } poll_state_e;

  typedef struct packed {
    logic [CS_FW-1:0]    cs;
    logic                rd_term;
    logic [BUDGET_W-1:0] budget;
  } wait_req_t;
endpackage

// File: rtl/nrp_cmd_decode.sv
module nrp_cmd_decode
  import nrp_pkg::*;
(
  input  logic [CMD_W-1:0] word_i,
  output logic             hit_o,
  output wait_req_t        req_o
);
  always_comb begin
    hit_o = word_i[RB_FLAG_BIT] && word_i[MARK_HI_BIT] && word_i[MARK_LO_BIT]
         && (word_i[MODE_LSB +: MODE_W] == MODE_POLL);
    req_o.cs      = word_i[CS_LSB +: CS_FW];
    req_o.rd_term = word_i[RDTERM_BIT];
    req_o.budget  = word_i[BUDGET_W-1:0];
  end
endmodule

// File: rtl/nrp_seq.sv
module nrp_seq
  import nrp_pkg::*;
#(
  parameter int TWB_W      = 8,
  parameter int RE_W       = 4,
  parameter int GAP_CYCLES = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  wait_req_t        req_i,
  input  logic             queue_empty_i,
  input  logic [TWB_W-1:0] twb_cycles_i,
  input  logic [RE_W-1:0]  re_low_i,
  input  logic [7:0]       io_i,
  output poll_state_e      state_o,
  output logic [CS_FW-1:0] cs_o,
  output logic             rdy_evt_o,
  output logic             tmo_evt_o
);
  localparam int GAP_W = $clog2(GAP_CYCLES + 1);
  localparam int CNT_A = (TWB_W > RE_W) ? TWB_W : RE_W;
  localparam int CNT_W = (CNT_A > GAP_W) ? CNT_A : GAP_W;
  localparam logic [CNT_W-1:0] GAP_LOAD = CNT_W'(GAP_CYCLES - 1);

  poll_state_e         state_q;
  wait_req_t           req_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [BUDGET_W-1:0] bud_q;
  logic                samp_q;
  logic [CNT_W-1:0]    re_load;
  logic                bud_out;

  assign re_load   = (re_low_i == '0) ? '0 : CNT_W'(re_low_i - 1'b1);
  assign bud_out   = (bud_q == '0);
  assign rdy_evt_o = (state_q == ST_RE_HI) && samp_q;
  assign tmo_evt_o = bud_out && ((state_q == ST_RE_LO) ||
                                 ((state_q == ST_RE_HI) && !samp_q));
  assign state_o   = state_q;
  assign cs_o      = req_q.cs;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      req_q   <= '0;
      cnt_q   <= '0;
      bud_q   <= '0;
      samp_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          req_q   <= req_i;
          samp_q  <= 1'b0;
          state_q <= ST_DRAIN;
        end
        ST_DRAIN: if (queue_empty_i) begin
          if (twb_cycles_i == '0) state_q <= ST_STAT_LO;
          else begin
            cnt_q   <= CNT_W'(twb_cycles_i - 1'b1);
            state_q <= ST_TWB;
          end
        end
        ST_TWB: begin
          if (cnt_q == '0) state_q <= ST_STAT_LO;
          else cnt_q <= cnt_q - 1'b1;
        end
        ST_STAT_LO: state_q <= ST_STAT_HI;
        ST_STAT_HI: begin
          cnt_q   <= GAP_LOAD;
          state_q <= ST_GAP1;
        end
        ST_GAP1: begin
          if (cnt_q == '0) begin
            cnt_q   <= GAP_LOAD;
            state_q <= ST_GAP2;
          end else cnt_q <= cnt_q - 1'b1;
        end
        ST_GAP2: begin
          if (cnt_q == '0) begin
            cnt_q   <= re_load;
            bud_q   <= req_q.budget;
            state_q <= ST_RE_LO;
          end else cnt_q <= cnt_q - 1'b1;
        end
        ST_RE_LO: begin
          if (bud_out) state_q <= ST_IDLE;
          else begin
            bud_q <= bud_q - 1'b1;
            if (cnt_q == '0) begin
              samp_q  <= io_i[READY_BIT];
              state_q <= ST_RE_HI;
            end else cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_RE_HI: begin
          if (samp_q) state_q <= req_q.rd_term ? ST_RD0_LO : ST_IDLE;
          else if (bud_out) state_q <= ST_IDLE;
          else begin
            bud_q   <= bud_q - 1'b1;
            cnt_q   <= re_load;
            state_q <= ST_RE_LO;
          end
        end
        ST_RD0_LO: state_q <= ST_RD0_HI;
        ST_RD0_HI: state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nrp_bus_drv.sv
module nrp_bus_drv
  import nrp_pkg::*;
#(
  parameter int NUM_CS = 4
) (
  input  poll_state_e      state_i,
  input  logic [CS_FW-1:0] cs_i,
  output logic [NUM_CS-1:0] ce_n_o,
  output logic             cle_o,
  output logic             we_n_o,
  output logic             re_n_o,
  output logic [7:0]       io_o,
  output logic             io_oe_o
);
  logic active, stat_lat, rd0_lat;

  always_comb begin
    stat_lat = (state_i == ST_STAT_LO) || (state_i == ST_STAT_HI);
    rd0_lat  = (state_i == ST_RD0_LO)  || (state_i == ST_RD0_HI);
    active   = !((state_i == ST_IDLE) || (state_i == ST_DRAIN) ||
                 (state_i == ST_TWB));
    cle_o    = stat_lat || rd0_lat;
    we_n_o   = !((state_i == ST_STAT_LO) || (state_i == ST_RD0_LO));
    re_n_o   = (state_i != ST_RE_LO);
    io_oe_o  = cle_o;
    io_o     = stat_lat ? OP_STATUS : (rd0_lat ? OP_READ0 : 8'h00);
  end

  for (genvar i = 0; i < NUM_CS; i++) begin : g_ce
    assign ce_n_o[i] = !(active && (cs_i == CS_FW'(i)));
  end
endmodule

// File: rtl/nrp_flags.sv
module nrp_flags #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_o[i] <= 1'b0;
      else         q_o[i] <= set_i[i] | (q_o[i] & ~clr_i[i]);
    end
  end
endmodule

// File: rtl/nand_rdy_poll.sv
module nand_rdy_poll
  import nrp_pkg::*;
#(
  parameter int NUM_CS     = 4,
  parameter int TWB_W      = 8,
  parameter int RE_W       = 4,
  parameter int GAP_CYCLES = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [31:0]       cmd_word_i,
  output logic              cmd_ready_o,
  input  logic              queue_empty_i,
  input  logic [TWB_W-1:0]  twb_cycles_i,
  input  logic [RE_W-1:0]   re_low_i,
  input  logic              cfg_irq_en_i,
  input  logic              clr_irq_i,
  input  logic              clr_tmo_i,
  output logic [NUM_CS-1:0] ce_n_o,
  output logic              cle_o,
  output logic              we_n_o,
  output logic              re_n_o,
  output logic [7:0]        io_o,
  output logic              io_oe_o,
  input  logic [7:0]        io_i,
  output logic              irq_o,
  output logic              timeout_o
);
  logic             hit, start, rdy_evt, tmo_evt;
  wait_req_t        req;
  poll_state_e      state;
  logic [CS_FW-1:0] cs;
  logic [1:0]       flags;

  assign cmd_ready_o = (state == ST_IDLE);
  assign start       = cmd_valid_i && cmd_ready_o && hit;

  nrp_cmd_decode u_dec (.word_i(cmd_word_i), .hit_o(hit), .req_o(req));

  nrp_seq #(.TWB_W(TWB_W), .RE_W(RE_W), .GAP_CYCLES(GAP_CYCLES)) u_seq (
    .clk_i, .rst_ni, .start_i(start), .req_i(req),
    .queue_empty_i, .twb_cycles_i, .re_low_i, .io_i,
    .state_o(state), .cs_o(cs), .rdy_evt_o(rdy_evt), .tmo_evt_o(tmo_evt)
  );

  nrp_bus_drv #(.NUM_CS(NUM_CS)) u_bus (
    .state_i(state), .cs_i(cs), .ce_n_o, .cle_o, .we_n_o, .re_n_o,
    .io_o, .io_oe_o
  );

  nrp_flags #(.N(2)) u_flags (
    .clk_i, .rst_ni,
    .set_i({tmo_evt, rdy_evt && cfg_irq_en_i}),
    .clr_i({clr_tmo_i, clr_irq_i}),
    .q_o(flags)
  );

  assign irq_o     = flags[0];
  assign timeout_o = flags[1];
endmodule

// File: rtl/nrp_chk.sv
module nrp_chk #(
  parameter int NUM_CS = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_ready_o,
  input logic [NUM_CS-1:0] ce_n_o,
  input logic              cle_o,
  input logic              we_n_o,
  input logic              re_n_o,
  input logic              cfg_irq_en_i,
  input logic              clr_irq_i,
  input logic              clr_tmo_i,
  input logic              irq_o,
  input logic              timeout_o
);
  assert_one_ce_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~ce_n_o));
  assert_we_needs_cle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_n_o |-> cle_o);
  assert_no_re_in_latch_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cle_o |-> re_n_o);
  assert_busy_blocks_cmd_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_n_o != '1) |-> !cmd_ready_o);
  assert_irq_needs_en_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(cfg_irq_en_i));
  assert_irq_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !clr_irq_i) |=> irq_o);
  assert_tmo_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timeout_o && !clr_tmo_i) |=> timeout_o);
  assert_single_outcome_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !($rose(irq_o) && $rose(timeout_o)));
endmodule

bind nand_rdy_poll nrp_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd_ready_o(cmd_ready_o), .ce_n_o(ce_n_o),
  .cle_o(cle_o), .we_n_o(we_n_o), .re_n_o(re_n_o), .cfg_irq_en_i(cfg_irq_en_i),
  .clr_irq_i(clr_irq_i), .clr_tmo_i(clr_tmo_i), .irq_o(irq_o),
  .timeout_o(timeout_o)
);

// File: tb/tb_nand_rdy_poll.sv
`timescale 1ns/1ps
module tb_nand_rdy_poll;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic cmd_valid_i = 1'b0;
  logic [31:0] cmd_word_i = '0;
  logic cmd_ready_o, queue_empty_i = 1'b1;
  logic [7:0] twb_cycles_i = '0;
  logic [3:0] re_low_i = 4'd1;
  logic cfg_irq_en_i = 1'b0, clr_irq_i = 1'b0, clr_tmo_i = 1'b0;
  logic [3:0] ce_n_o;
  logic cle_o, we_n_o, re_n_o, io_oe_o, irq_o, timeout_o;
  logic [7:0] io_o, io_i;

  int n_chk = 0, n_fail = 0;
  int rd_cnt = 0, rd_base = 0, busy_reads = 0;

  always #2.5 clk_i = ~clk_i;

  nand_rdy_poll dut (.*);

  // flash model: status byte only while RE# low, ready after busy_reads reads
  always @(posedge re_n_o) rd_cnt++;
  assign io_i = re_n_o ? 8'h00 :
                (((rd_cnt - rd_base) >= busy_reads) ? 8'hE0 : 8'hA0);

  int o_twb, o_reads, o_gap, o_lat_n, o_cle_n, o_lo_min, o_lo_max, o_hi_min;
  logic [7:0] o_lat [4];
  logic [3:0] o_ce;
  bit o_done;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int cs, input bit rd, input int bud,
                                     input logic [3:0] mode = 4'hB,
                                     input bit m16 = 1, input bit m18 = 1,
                                     input bit rb = 1);
    logic [31:0] w = '0;
    w[23:22] = 2'(cs); w[20] = rb; w[18] = m18; w[17] = rd; w[16] = m16;
    w[13:10] = mode; w[9:0] = 10'(bud);
    return w;
  endfunction

  task automatic send(input logic [31:0] w);
    @(negedge clk_i);
    cmd_word_i = w; cmd_valid_i = 1'b1;
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
  endtask

  // releases the queue and records bus activity until the engine is idle again
  task automatic observe();
    bit started = 0, prev_re = 1;
    int lo_run = 0, hi_run = 0, gap_cnt = 0;
    o_twb = 0; o_reads = 0; o_gap = -1; o_lat_n = 0; o_cle_n = 0;
    o_lo_min = 99; o_lo_max = 0; o_hi_min = 99; o_ce = '1; o_done = 0;
    rd_base = rd_cnt;
    queue_empty_i = 1'b1;
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk_i);
      if (!started) begin
        if (ce_n_o == 4'hF) o_twb++;
        else begin started = 1; o_ce = ce_n_o; end
      end
      if (started) begin
        if (cle_o) begin
          o_cle_n++;
          if (!we_n_o && o_lat_n < 4) begin o_lat[o_lat_n] = io_o; o_lat_n++; end
          if (o_reads == 0) gap_cnt = 0;
        end else if (o_reads == 0 && re_n_o) gap_cnt++;
        if (!re_n_o) begin
          if (prev_re) begin
            o_reads++;
            if (o_reads == 1) o_gap = gap_cnt;
            else if (hi_run < o_hi_min) o_hi_min = hi_run;
          end
          lo_run++;
        end else begin
          if (!prev_re) begin
            if (lo_run < o_lo_min) o_lo_min = lo_run;
            if (lo_run > o_lo_max) o_lo_max = lo_run;
            lo_run = 0; hi_run = 0;
          end
          hi_run++;
        end
        prev_re = re_n_o;
        if (cmd_ready_o) begin o_done = 1; break; end
      end
    end
  endtask

  task automatic t_reset();
    chk(ce_n_o == 4'hF, "R12 ce_n", int'(ce_n_o), 15);
    chk(!cle_o && we_n_o && re_n_o && !io_oe_o, "R12 strobes",
        {cle_o, we_n_o, re_n_o, io_oe_o}, 6);
    chk(!irq_o && !timeout_o, "R12 flags", {irq_o, timeout_o}, 0);
    chk(cmd_ready_o, "R12 cmd_ready", cmd_ready_o, 1);
  endtask

  task automatic t_ignore();
    logic [31:0] bad [3];
    bad[0] = mk(1, 1, 100, 4'hA);
    bad[1] = mk(1, 1, 100, 4'hB, 1, 0);
    bad[2] = mk(1, 1, 100, 4'hB, 1, 1, 0);
    cfg_irq_en_i = 1'b1;
    foreach (bad[k]) begin
      int act = 0;
      send(bad[k]);
      repeat (30) begin
        @(negedge clk_i);
        if (ce_n_o != 4'hF || !cmd_ready_o || irq_o) act++;
      end
      chk(act == 0, "R1 non-wait word ignored", act, 0);
    end
  endtask

  task automatic t_read_wait();
    int bad = 0;
    cfg_irq_en_i = 1'b1; twb_cycles_i = 8'd4; re_low_i = 4'd2; busy_reads = 3;
    queue_empty_i = 1'b0;
    send(mk(2, 1, 900));
    for (int c = 0; c < 10; c++) begin
      cmd_word_i = mk(1, 0, 50); cmd_valid_i = 1'b1;
      @(negedge clk_i);
      if (ce_n_o != 4'hF) bad++;
      if (cmd_ready_o) bad += 100;
    end
    cmd_valid_i = 1'b0;
    chk(bad == 0, "R3 R2 parked until queue drains", bad, 0);
    observe();
    chk(o_done, "R7 wait completes", o_done, 1);
    chk(o_twb == 4, "R3 tWB clocks", o_twb, 4);
    chk(o_ce == 4'b1011, "R4 chip select 2", int'(o_ce), 11);
    chk(o_lat_n == 2 && o_lat[0] == 8'h70, "R4 status latch", o_lat_n, 2);
    chk(o_lat_n == 2 && o_lat[1] == 8'h00, "R9 READ0 latch", int'(o_lat[1]), 0);
    chk(o_cle_n == 4, "R4 CLE two clocks per latch", o_cle_n, 4);
    chk(o_gap == 10, "R5 idle gap", o_gap, 10);
    chk(o_lo_min == 2 && o_lo_max == 2, "R6 RE low width", o_lo_max, 2);
    chk(o_hi_min >= 1, "R6 RE high between reads", o_hi_min, 1);
    chk(o_reads == 4, "R7 reads until bit6", o_reads, 4);
    chk(irq_o && !timeout_o, "R7 irq set", {irq_o, timeout_o}, 2);
    repeat (10) @(negedge clk_i);
    chk(ce_n_o == 4'hF && irq_o, "R2 second word not taken, irq held",
        int'(ce_n_o), 15);
  endtask

  task automatic t_clear_irq();
    @(negedge clk_i); clr_irq_i = 1'b1;
    @(negedge clk_i); clr_irq_i = 1'b0;
    chk(!irq_o, "R11 irq cleared", irq_o, 0);
  endtask

  task automatic t_write_wait();
    cfg_irq_en_i = 1'b0; twb_cycles_i = 8'd0; re_low_i = 4'd0; busy_reads = 1;
    queue_empty_i = 1'b0;
    send(mk(0, 0, 900));
    observe();
    chk(o_twb == 0, "R3 zero tWB", o_twb, 0);
    chk(o_ce == 4'b1110, "R4 chip select 0", int'(o_ce), 14);
    chk(o_lat_n == 1, "R9 no READ0 without read flag", o_lat_n, 1);
    chk(o_lo_min == 1 && o_lo_max == 1, "R6 zero width as one", o_lo_max, 1);
    chk(o_reads == 2, "R7 ready on second read", o_reads, 2);
    repeat (3) @(negedge clk_i);
    chk(!irq_o && !timeout_o, "R8 no irq when disabled", {irq_o, timeout_o}, 0);
  endtask

  task automatic t_timeout();
    cfg_irq_en_i = 1'b1; twb_cycles_i = 8'd2; re_low_i = 4'd3; busy_reads = 1000;
    queue_empty_i = 1'b0;
    send(mk(3, 1, 25));
    observe();
    chk(o_done, "R10 returns to idle", o_done, 1);
    chk(o_reads == 7, "R10 reads within budget", o_reads, 7);
    chk(o_lat_n == 1, "R10 no READ0 on timeout", o_lat_n, 1);
    chk(timeout_o && !irq_o, "R10 timeout flag", {irq_o, timeout_o}, 1);
    chk(ce_n_o == 4'hF, "R10 CE released", int'(ce_n_o), 15);
    @(negedge clk_i); clr_irq_i = 1'b1;
    @(negedge clk_i); clr_irq_i = 1'b0;
    chk(timeout_o, "R11 irq clear leaves timeout", timeout_o, 1);
    clr_tmo_i = 1'b1;
    @(negedge clk_i); clr_tmo_i = 1'b0;
    chk(!timeout_o, "R11 timeout cleared", timeout_o, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_ignore();
    t_read_wait();
    t_clear_irq();
    t_write_wait();
    t_timeout();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule